// File: doc/BRIEF.md
# Dual-Clock FIFO with Mark and Retransmit

This block is a first-in first-out buffer whose write side and read side each run on their own clock, with no frequency relation between the two. A master reset picks one of two read timing modes from the `mode_i` input. In standard mode a word reaches `rdata` only when a read is requested. In fall-through mode the oldest stored word is presented on its own and stays there until it is consumed. The two status outputs change meaning with the mode, and a half-full indication is available in both modes.

A read-side mark lets a consumer replay a stretch of the stream. While `mark_i` is held high, the block remembers the position of the word that the next read would deliver, or the word being presented in fall-through mode. It also protects that word and every later one from being overwritten. Pulsing `rt_n` low rewinds the read side to the remembered position, so the stream is delivered again from there. A partial reset empties the buffer and keeps the timing mode. A master reset empties it and samples the mode again.

Top module: `fifo_rt_core`

## Requirements
- R1: The timing mode is sampled from `mode_i` on every write-clock and read-clock edge while `mrst_n` is low. A value of 0 selects standard mode and 1 selects fall-through mode. Changes on `mode_i` after `mrst_n` returns high have no effect.
- R2: In standard mode, `rdata` changes only on a read-clock edge with `rd_en` high while the FIFO is not empty. It then shows the oldest unread word, in write order. `rdata` is 0 after reset.
- R3: In fall-through mode, a word written into an empty FIFO appears on `rdata` with `rd_flag` high at the third rising read-clock edge after the write edge, with `rd_en` low. `rd_flag` is still low after the second such edge.
- R4: In fall-through mode, a presented word stays on `rdata` until a read-clock edge with `rd_en` high. That edge presents the next stored word, or drops `rd_flag` when no word is stored.
- R5: In standard mode, `rd_flag` high means empty and `wr_flag` high means full. In fall-through mode, `rd_flag` high means a word is presented and `wr_flag` high means there is room to write.
- R6: A write while full changes nothing. A standard-mode read while empty leaves `rdata` unchanged. Neither adds, loses or reorders words.
- R7: `half_full` is high exactly when more than DEPTH/2 locations are held, counted on the write side.
- R8: A read-clock edge with `rt_n` low while a mark is held moves the read side back to the marked word. The next delivered word is the marked word, followed by the words written after it, in order.
- R9: `rt_n` low while no mark is held has no effect on the read position.
- R10: While a mark is held, the marked word and all later words count as occupied, so the FIFO stays full even after they are read. Releasing the mark frees them within a few cycles of both clocks.
- R11: Partial reset (`prst_n` low) and master reset (`mrst_n` low) both empty the FIFO. Partial reset keeps the timing mode, and master reset takes the new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| mrst_n | input | 1 | Master reset, active low, sampled by both clocks |
| prst_n | input | 1 | Partial reset, active low, sampled by both clocks |
| mode_i | input | 1 | Timing mode sampled during master reset (1 = fall-through) |
| wr_en | input | 1 | Write request |
| wdata | input | DW | Write data |
| wr_flag | output | 1 | Full (standard) or room-to-write (fall-through) |
| half_full | output | 1 | More than half the locations are held |
| rd_en | input | 1 | Read request |
| rdata | output | DW | Read data register |
| rd_flag | output | 1 | Empty (standard) or word presented (fall-through) |
| mark_i | input | 1 | Hold high to keep a mark on the current read position |
| rt_n | input | 1 | Retransmit request, active low |

## Verification
A read pointer that drifts shows up at once as a wrong or repeated word on `rdata` at the next delivered word. This is why every read is compared with the arithmetic sequence the bench wrote. A wrong crossed pointer shows up a few cycles later as a full, half-full or empty indication that disagrees with the count of writes minus reads. A lost mark or an unprotected marked region appears when the retransmitted stream differs from the one first delivered, or when `wr_flag` drops while the mark is still held. A mode register that does not hold its value after reset is caught on the first flag sample after `mode_i` is flipped.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rd_mode_e;

  function automatic logic [31:0] bin2gray(input logic [31:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [31:0] gray2bin(input logic [31:0] g);
    logic [31:0] b;
    b[31] = g[31];
    for (int i = 30; i >= 0; i--) begin
      b[i] = b[i+1] ^ g[i];
    end
    return b;
  endfunction

endpackage

// File: rtl/fifo_rt_sync.sv
module fifo_rt_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    logic [W-1:0] r;
    if (i == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) r <= '0;
        else        r <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) r <= '0;
        else        r <= g_stage[i-1].r;
      end
    end
  end

  assign q = g_stage[STAGES-1].r;

endmodule

// File: rtl/fifo_rt_wr.sv
module fifo_rt_wr
  import fifo_rt_pkg::*;
#(
  parameter int AW = 3
) (
  input  logic        wclk,
  input  logic        mrst_n,
  input  logic        prst_n,
  input  logic        mode_i,
  input  logic        wr_en,
  input  logic [AW:0] guard_sync_g,
  output logic [AW:0] wptr_g,
  output logic [AW-1:0] waddr,
  output logic        push,
  output logic        wr_flag,
  output logic        half_full
);

  localparam int          DEPTH = 1 << AW;
  localparam logic [AW:0] CAP   = (AW+1)'(DEPTH);
  localparam logic [AW:0] HALF  = CAP >> 1;
  localparam logic [AW:0] ONE   = (AW+1)'(1);

  rd_mode_e    mode;
  logic [AW:0] wptr;
  logic [AW:0] gbin;
  logic [AW:0] used;
  logic        full;
  logic        rst;

  assign rst       = !mrst_n || !prst_n;
  assign gbin      = (AW+1)'(gray2bin(32'(guard_sync_g)));
  assign used      = wptr - gbin;
  assign full      = (used == CAP);
  assign push      = wr_en && !full;
  assign waddr     = wptr[AW-1:0];
  assign half_full = (used > HALF);
  assign wr_flag   = (mode == MODE_FWFT) ? !full : full;

  always_ff @(posedge wclk) begin
    if (!mrst_n) mode <= rd_mode_e'(mode_i);
    if (rst) begin
      wptr   <= '0;
      wptr_g <= '0;
    end else if (push) begin
      wptr   <= wptr + ONE;
      wptr_g <= (AW+1)'(bin2gray(32'(wptr + ONE)));
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge wclk) disable iff (rst)
    (wr_en && full) |=> $stable(wptr)); // R6
  AST_USED_BOUNDED: assert property (@(posedge wclk) disable iff (rst)
    used <= CAP); // R6
  AST_HALF_BEFORE_FULL: assert property (@(posedge wclk) disable iff (rst)
    full |-> half_full); // R7

endmodule

// File: rtl/fifo_rt_rd.sv
module fifo_rt_rd
  import fifo_rt_pkg::*;
#(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          mode_i,
  input  logic          rd_en,
  input  logic          mark_i,
  input  logic          rt_n,
  input  logic [AW:0]   wsync_g,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  output logic          rd_flag,
  output logic [AW:0]   guard_g
);

  localparam logic [AW:0] ONE = (AW+1)'(1);

  rd_mode_e    mode;
  logic [AW:0] rptr;
  logic [AW:0] wbin;
  logic [AW:0] head;
  logic [AW:0] mark_ptr;
  logic [AW:0] guard;
  logic [AW:0] target;
  logic        ov;
  logic        mark_valid;
  logic        rst;
  logic        fwft;
  logic        empty_int;
  logic        take;
  logic        drop;
  logic        rt_go;
  logic        mark_rec;

  assign rst       = !mrst_n || !prst_n;
  assign fwft      = (mode == MODE_FWFT);
  assign wbin      = (AW+1)'(gray2bin(32'(wsync_g)));
  assign empty_int = (rptr == wbin);
  assign head      = rptr - ((fwft && ov) ? ONE : '0);
  assign rt_go     = !rt_n && mark_valid;
  assign mark_rec  = mark_i && !mark_valid;
  assign take      = !empty_int && (fwft ? (!ov || rd_en) : rd_en);
  assign drop      = fwft && ov && rd_en && empty_int;
  assign target    = mark_valid ? mark_ptr : head;
  assign raddr     = rptr[AW-1:0];
  assign rd_flag   = fwft ? ov : empty_int;

  always_ff @(posedge rclk) begin
    if (!mrst_n) mode <= rd_mode_e'(mode_i);
    if (rst) begin
      rptr       <= '0;
      rdata      <= '0;
      ov         <= 1'b0;
      mark_valid <= 1'b0;
      mark_ptr   <= '0;
      guard      <= '0;
      guard_g    <= '0;
    end else begin
      mark_valid <= mark_i;
      if (mark_rec) mark_ptr <= head;
      if (rt_go) begin
        rptr <= mark_ptr;
        ov   <= 1'b0;
      end else if (take) begin
        rdata <= mem_rdata;
        rptr  <= rptr + ONE;
        ov    <= 1'b1;
      end else if (drop) begin
        ov <= 1'b0;
      end
      if (guard != target) begin
        guard   <= guard + ONE;
        guard_g <= (AW+1)'(bin2gray(32'(guard + ONE)));
      end
    end
  end

  AST_NO_UNDERFLOW: assert property (@(posedge rclk) disable iff (rst)
    (!fwft && rd_en && empty_int && rt_n) |=> ($stable(rptr) && $stable(rdata))); // R6
  AST_RT_REWIND: assert property (@(posedge rclk) disable iff (rst)
    rt_go |=> (rptr == $past(mark_ptr))); // R8
  AST_RT_IGNORED: assert property (@(posedge rclk) disable iff (rst)
    (!rt_n && !mark_valid && !rd_en && !fwft) |=> $stable(rptr)); // R9
  AST_FWFT_HOLD: assert property (@(posedge rclk) disable iff (rst)
    (fwft && ov && !rd_en && rt_n) |=> ($stable(rdata) && rd_flag)); // R4
  AST_GUARD_STEP: assert property (@(posedge rclk) disable iff (rst)
    $countones(guard_g ^ $past(guard_g)) <= 1); // R10

endmodule

// File: rtl/fifo_rt_core.sv
module fifo_rt_core #(
  parameter int DW    = 8,
  parameter int DEPTH = 8
) (
  input  logic          wclk,
  input  logic          rclk,
  input  logic          mrst_n,
  input  logic          prst_n,
  input  logic          mode_i,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic          wr_flag,
  output logic          half_full,
  input  logic          rd_en,
  output logic [DW-1:0] rdata,
  output logic          rd_flag,
  input  logic          mark_i,
  input  logic          rt_n
);

  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wptr_g, wsync_g, guard_g, guard_sync_g;
  logic [AW-1:0] waddr, raddr;
  logic          push;
  logic          rst_all_n;

  assign rst_all_n = mrst_n && prst_n;

  always_ff @(posedge wclk) begin
    if (push) mem[waddr] <= wdata;
  end

  fifo_rt_wr #(.AW(AW)) u_wr (
    .wclk(wclk), .mrst_n(mrst_n), .prst_n(prst_n), .mode_i(mode_i),
    .wr_en(wr_en), .guard_sync_g(guard_sync_g), .wptr_g(wptr_g),
    .waddr(waddr), .push(push), .wr_flag(wr_flag), .half_full(half_full)
  );

  fifo_rt_sync #(.W(PW), .STAGES(2)) u_w2r (
    .clk(rclk), .rst_n(rst_all_n), .d(wptr_g), .q(wsync_g)
  );

  fifo_rt_sync #(.W(PW), .STAGES(2)) u_r2w (
    .clk(wclk), .rst_n(rst_all_n), .d(guard_g), .q(guard_sync_g)
  );

  fifo_rt_rd #(.AW(AW), .DW(DW)) u_rd (
    .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n), .mode_i(mode_i),
    .rd_en(rd_en), .mark_i(mark_i), .rt_n(rt_n), .wsync_g(wsync_g),
    .mem_rdata(mem[raddr]), .raddr(raddr), .rdata(rdata),
    .rd_flag(rd_flag), .guard_g(guard_g)
  );

endmodule

// File: tb/fifo_rt_core_bench.sv
module fifo_rt_core_bench;

  localparam int WCLK_PERIOD = 10;
  localparam int RCLK_PERIOD = 14;
  localparam int DEPTH       = 8;

  logic       wclk = 1'b1;
  logic       rclk = 1'b0;
  logic       mrst_n = 1'b0;
  logic       prst_n = 1'b1;
  logic       mode_i = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wdata = '0;
  logic       rd_en = 1'b0;
  logic       mark_i = 1'b0;
  logic       rt_n = 1'b1;
  logic       wr_flag, half_full, rd_flag;
  logic [7:0] rdata;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(WCLK_PERIOD/2) wclk = ~wclk;
  always #(RCLK_PERIOD/2) rclk = ~rclk;

  fifo_rt_core #(.DW(8), .DEPTH(DEPTH)) u_fifo_rt_core (
    .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
    .mode_i(mode_i), .wr_en(wr_en), .wdata(wdata), .wr_flag(wr_flag),
    .half_full(half_full), .rd_en(rd_en), .rdata(rdata), .rd_flag(rd_flag),
    .mark_i(mark_i), .rt_n(rt_n)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic do_mreset(input logic m);
    @(negedge rclk);
    mrst_n = 1'b0;
    mode_i = m;
    repeat (4) @(negedge rclk);
    mrst_n = 1'b1;
    mode_i = ~m;
    repeat (2) @(negedge rclk);
    @(negedge wclk);
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge wclk);
    wr_en = 1'b1;
    wdata = d;
    @(negedge wclk);
    wr_en = 1'b0;
  endtask

  task automatic rd();
    @(negedge rclk);
    rd_en = 1'b1;
    @(negedge rclk);
    rd_en = 1'b0;
  endtask

  task automatic rt_pulse();
    @(negedge rclk);
    rt_n = 1'b0;
    @(negedge rclk);
    rt_n = 1'b1;
  endtask

  // Write one word into an empty fall-through FIFO and count read edges.
  task automatic fall_through(input logic [7:0] d, input string req);
    @(negedge wclk);
    wr_en = 1'b1;
    wdata = d;
    @(posedge wclk);
    fork
      begin
        @(negedge wclk);
        wr_en = 1'b0;
      end
      begin
        @(posedge rclk); #1;
        chk(req, "not ready after edge 1", int'(rd_flag), 0);
        @(posedge rclk); #1;
        chk(req, "not ready after edge 2", int'(rd_flag), 0);
        @(posedge rclk); #1;
        chk(req, "ready after edge 3", int'(rd_flag), 1);
        chk(req, "word after edge 3", int'(rdata), int'(d));
      end
    join
  endtask

  initial begin
    // ---------------- standard mode ----------------
    do_mreset(1'b0);
    chk("R11", "std reset empty", int'(rd_flag), 1);
    chk("R5", "std reset not full", int'(wr_flag), 0);
    chk("R7", "reset half_full", int'(half_full), 0);
    chk("R2", "reset rdata", int'(rdata), 0);
    for (int i = 0; i < DEPTH; i++) begin
      wr(8'hA0 + 8'(i));
      if (i == DEPTH/2 - 1) chk("R7", "half at DEPTH/2", int'(half_full), 0);
      if (i == DEPTH/2)     chk("R7", "half above DEPTH/2", int'(half_full), 1);
    end
    chk("R5", "std full", int'(wr_flag), 1);
    wr(8'hEE);
    chk("R6", "still full after extra write", int'(wr_flag), 1);
    repeat (4) @(negedge rclk);
    chk("R5", "std not empty", int'(rd_flag), 0);
    chk("R2", "no read no output", int'(rdata), 0);
    chk("R1", "mode flip ignored, std", int'(rd_flag), 0);
    for (int i = 0; i < DEPTH; i++) begin
      rd();
      chk("R2", "std read order", int'(rdata), int'(8'hA0 + 8'(i)));
    end
    chk("R5", "std empty after drain", int'(rd_flag), 1);
    rd();
    chk("R6", "read on empty keeps rdata", int'(rdata), int'(8'hA7));
    repeat (6) @(negedge wclk);
    chk("R5", "std not full after drain", int'(wr_flag), 0);
    chk("R7", "half clear after drain", int'(half_full), 0);

    // ---------------- mark and retransmit, standard ----------------
    do_mreset(1'b0);
    @(negedge rclk);
    mark_i = 1'b1;
    @(negedge rclk);
    for (int i = 0; i < DEPTH; i++) wr(8'hB0 + 8'(i));
    chk("R5", "full before mark reads", int'(wr_flag), 1);
    repeat (4) @(negedge rclk);
    for (int i = 0; i < 4; i++) begin
      rd();
      chk("R2", "pre-retransmit order", int'(rdata), int'(8'hB0 + 8'(i)));
    end
    repeat (6) @(negedge wclk);
    chk("R10", "marked words still occupy", int'(wr_flag), 1);
    rt_pulse();
    for (int i = 0; i < DEPTH; i++) begin
      rd();
      chk("R8", "replay order", int'(rdata), int'(8'hB0 + 8'(i)));
    end
    chk("R8", "empty after replay", int'(rd_flag), 1);
    @(negedge rclk);
    mark_i = 1'b0;
    repeat (12) @(negedge rclk);
    repeat (4) @(negedge wclk);
    chk("R10", "mark release frees space", int'(wr_flag), 0);
    chk("R10", "mark release clears half", int'(half_full), 0);
    wr(8'hC0); wr(8'hC1); wr(8'hC2);
    repeat (4) @(negedge rclk);
    rd();
    chk("R2", "unmarked first", int'(rdata), int'(8'hC0));
    rt_pulse();
    rd();
    chk("R9", "retransmit without mark ignored", int'(rdata), int'(8'hC1));
    rd();
    chk("R9", "order kept after ignored rt", int'(rdata), int'(8'hC2));

    // ---------------- fall-through mode ----------------
    do_mreset(1'b1);
    chk("R5", "fwft reset not ready", int'(rd_flag), 0);
    chk("R5", "fwft reset input ready", int'(wr_flag), 1);
    fall_through(8'hD0, "R3");
    wr(8'hD1); wr(8'hD2); wr(8'hD3);
    repeat (4) @(negedge rclk);
    chk("R4", "held without rd_en", int'(rdata), int'(8'hD0));
    chk("R1", "mode flip ignored, fwft", int'(rd_flag), 1);
    @(negedge rclk);
    mark_i = 1'b1;
    rd();
    chk("R4", "next word on rd_en", int'(rdata), int'(8'hD1));
    rd();
    chk("R4", "next word on rd_en 2", int'(rdata), int'(8'hD2));
    rt_pulse();
    chk("R8", "fwft output cleared by rt", int'(rd_flag), 0);
    @(negedge rclk);
    chk("R8", "fwft marked word ready", int'(rd_flag), 1);
    chk("R8", "fwft marked word again", int'(rdata), int'(8'hD0));
    mark_i = 1'b0;
    for (int i = 1; i < 4; i++) begin
      rd();
      chk("R4", "fwft replay order", int'(rdata), int'(8'hD0 + 8'(i)));
    end
    rd();
    chk("R4", "ready drops when drained", int'(rd_flag), 0);
    repeat (8) @(negedge rclk);
    for (int i = 0; i < DEPTH; i++) wr(8'hF0 + 8'(i));
    chk("R5", "fwft input not ready when full", int'(wr_flag), 0);
    repeat (4) @(negedge rclk);
    rd();
    chk("R4", "fwft second stored word", int'(rdata), int'(8'hF1));
    repeat (4) @(negedge rclk);
    repeat (4) @(negedge wclk);
    chk("R5", "fwft input ready after consume", int'(wr_flag), 1);

    // ---------------- partial and master reset ----------------
    @(negedge rclk);
    chk("R11", "data present before partial reset", int'(rd_flag), 1);
    prst_n = 1'b0;
    mode_i = 1'b0;
    repeat (4) @(negedge rclk);
    prst_n = 1'b1;
    repeat (2) @(negedge rclk);
    @(negedge wclk);
    chk("R11", "partial reset keeps fwft (rd_flag)", int'(rd_flag), 0);
    chk("R11", "partial reset keeps fwft (wr_flag)", int'(wr_flag), 1);
    chk("R11", "partial reset clears half", int'(half_full), 0);
    fall_through(8'h5A, "R11");
    do_mreset(1'b0);
    chk("R11", "master reset takes std (empty)", int'(rd_flag), 1);
    chk("R11", "master reset takes std (not full)", int'(wr_flag), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge wclk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule